// File: doc/BRIEF.md
# Pipelined synchronous SRAM core

This block is a small single-port synchronous SRAM. It captures address, chip select, write controls and write data on the rising clock edge. Each byte lane is nine bits wide: eight data bits plus one parity bit. Two static mode inputs shape the read path. `flow_mode` decides whether read data bypasses the output register. `dual_desel` decides whether a deselect drops the output driver at the same latency as a read, or holds the last read data for one more cycle first.

On reads, parity is checked per lane. The expected sense is even or odd, chosen by a static input. The output enable and the sleep input act combinationally on the drive signal. The bidirectional data bus is split into `din`, `dout` and `dout_en`, so the pads stay outside the block. Burst address generation is not part of this block; it belongs to a separate address generator ahead of it.

Tying all three mode inputs low gives the default configuration: pipelined reads, single-cycle release and even parity.

Top module: `sync_sram_core`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `dout_en` and `par_err` are 0.
- R2: With `flow_mode`=1, a read presented before edge E is shown on `dout`, with `dout_en`=1, after edge E+1. A read is `chip_sel`=1 that is not a write.
- R3: With `flow_mode`=0, a read presented before edge E is shown on `dout` after edge E+2.
- R4: With `wr_all`=1 and `chip_sel`=1, every lane at the address is written, whatever `wr_byte` and `lane_sel` are.
- R5: With `wr_all`=0, a write needs `wr_byte`=1 and at least one `lane_sel` bit set. Only lane i with `lane_sel[i]`=1 is written, where lane i is `din[9i+8:9i]`. Otherwise a selected cycle is a read and leaves memory unchanged.
- R6: With `dual_desel`=1, a deselect (`chip_sel`=0) that directly follows a read keeps `dout_en`=1 with unchanged `dout` for one more cycle after the read's data cycle. The driver then turns off.
- R7: With `dual_desel`=0, a deselect presented before edge E turns the driver off after the same edge at which a read presented before E would first drive. The preceding read's data therefore drives for exactly one cycle.
- R8: Bit 9i+8 is the parity bit of lane i. If the XOR of a lane's nine bits differs from `par_odd` (0 = even, 1 = odd), `par_err` is 1. This is reported exactly in the read data cycle and is 0 in other cycles.
- R9: `oe`=0 forces `dout_en` to 0 at once, without waiting for a clock edge. Returning `oe` to 1 restores the drive in the same cycle.
- R10: `sleep`=1 forces `dout_en` to 0 at once. Commands presented while asleep are ignored: no write takes place and no read is ever driven. Stored contents are kept.
- R11: A new read address is accepted on every cycle. Consecutive reads appear on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the control pipeline |
| flow_mode | input | 1 | 1: read data bypasses the output register |
| dual_desel | input | 1 | 1: deselect holds the driver one extra cycle |
| par_odd | input | 1 | Parity sense, 0 even, 1 odd |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous low-power request, active high |
| chip_sel | input | 1 | Command valid; 0 is a deselect |
| wr_all | input | 1 | Write every lane |
| wr_byte | input | 1 | Write the lanes named by `lane_sel` |
| lane_sel | input | LANES | Per-lane write select |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, lane i at bits 9i+8:9i |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Output driver enable for `dout` |
| par_err | output | 1 | Parity mismatch on the data shown |

## Verification
The hardest case to reach is the interaction of a deselect with the read just before it. The single-cycle and dual-cycle rules differ only in the cycle after the read data, so the stimulus issues a read immediately followed by a deselect in all four combinations of the two mode pins. It then samples the driver on the data cycle and on each following cycle. A command that sleep must swallow is equally hidden. The bench issues a write and a read while asleep, then releases sleep before the ignored read would have reached the outputs, and reads the address back to show the stored word did not change.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

  // Command captured at the input register stage.
  typedef struct packed {
    logic rd;   // selected, not a write
    logic wr;   // selected write with at least one lane
    logic ds;   // deselect
  } sram_cmd_t;

  localparam sram_cmd_t CMD_IDLE = '{rd: 1'b0, wr: 1'b0, ds: 1'b0};

endpackage

// File: rtl/sram_cmd_capture.sv
module sram_cmd_capture
  import sram_core_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep,
  input  logic                    chip_sel,
  input  logic                    wr_all,
  input  logic                    wr_byte,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output sram_cmd_t               cmd_q,
  output logic [ADDR_W-1:0]       addr_q,
  output logic [LANES*LANE_W-1:0] wdata_q,
  output logic [LANES-1:0]        wmask_q
);

  logic wr_req;

  // Global write overrides the lane controls; a lane write needs a lane.
  assign wr_req = chip_sel & (wr_all | (wr_byte & (|lane_sel)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_IDLE;
    end else if (sleep) begin
      cmd_q <= CMD_IDLE;          // commands ignored while asleep
    end else begin
      cmd_q.rd <= chip_sel & ~wr_req;
      cmd_q.wr <= wr_req;
      cmd_q.ds <= ~chip_sel;
    end
  end

  // Datapath registers carry no reset so they map onto plain flops.
  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= din;
    wmask_q <= wr_all ? {LANES{1'b1}} : lane_sel;
  end

endmodule

// File: rtl/sram_lane_ram.sv
module sram_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // One port, registered read, read data held when not reading.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end

endmodule

// File: rtl/sram_read_out.sv
module sram_read_out #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flow_mode,
  input  logic                    dual_desel,
  input  logic                    par_odd,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic                    rd_in,
  input  logic                    ds_in,
  input  logic [LANES*LANE_W-1:0] ram_q,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en,
  output logic                    par_err
);

  localparam int DATA_W = LANES * LANE_W;

  logic              rd1, rd2, rd3, ds1, ds2;
  logic [DATA_W-1:0] out_q;
  logic              rd_now, ds_now, rd_prev, drive;
  logic [LANES-1:0]  lane_bad;

  // Control tags follow the data: stage 1 aligns with ram_q, stage 2 with out_q.
  always_ff @(posedge clk) begin
    if (rst) begin
      {rd1, rd2, rd3, ds1, ds2} <= '0;
    end else begin
      rd1 <= rd_in;
      rd2 <= rd1;
      rd3 <= rd2;
      ds1 <= ds_in;
      ds2 <= ds1;
    end
  end

  always_ff @(posedge clk) begin
    if (rd1) out_q <= ram_q;
  end

  always_comb begin
    if (flow_mode) begin
      dout    = ram_q;
      rd_now  = rd1;
      ds_now  = ds1;
      rd_prev = rd2;
    end else begin
      dout    = out_q;
      rd_now  = rd2;
      ds_now  = ds2;
      rd_prev = rd3;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_par
    assign lane_bad[g] = (^dout[g*LANE_W +: LANE_W]) ^ par_odd;
  end

  // Dual-cycle release: a deselect right after a read keeps the driver on.
  assign drive   = rd_now | (dual_desel & ds_now & rd_prev);
  assign dout_en = drive & oe & ~sleep;
  assign par_err = rd_now & (|lane_bad);

  // R6: the extra hold cycle repeats the previous data unchanged.
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (drive && !rd_now && flow_mode == $past(flow_mode)) |-> $stable(dout));

endmodule

// File: rtl/sync_sram_core.sv
module sync_sram_core
  import sram_core_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flow_mode,
  input  logic                    dual_desel,
  input  logic                    par_odd,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic                    chip_sel,
  input  logic                    wr_all,
  input  logic                    wr_byte,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en,
  output logic                    par_err
);

  localparam int DATA_W = LANES * LANE_W;

  sram_cmd_t         cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  wmask_q;
  logic [DATA_W-1:0] ram_q;

  sram_cmd_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .chip_sel (chip_sel),
    .wr_all   (wr_all),
    .wr_byte  (wr_byte),
    .lane_sel (lane_sel),
    .addr     (addr),
    .din      (din),
    .cmd_q    (cmd_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .wmask_q  (wmask_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_ram #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_ram (
      .clk   (clk),
      .we    (cmd_q.wr & wmask_q[g]),
      .re    (cmd_q.rd),
      .addr  (addr_q),
      .wdata (wdata_q[g*LANE_W +: LANE_W]),
      .rdata (ram_q[g*LANE_W +: LANE_W])
    );
  end

  sram_read_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .flow_mode  (flow_mode),
    .dual_desel (dual_desel),
    .par_odd    (par_odd),
    .oe         (oe),
    .sleep      (sleep),
    .rd_in      (cmd_q.rd),
    .ds_in      (cmd_q.ds),
    .ram_q      (ram_q),
    .dout       (dout),
    .dout_en    (dout_en),
    .par_err    (par_err)
  );

  // Port-level view of commands, used by the timing properties below.
  logic       rd_req_p, ds_req_p;
  logic [2:0] since_rst;

  assign rd_req_p = chip_sel & ~sleep & ~(wr_all | (wr_byte & (|lane_sel)));
  assign ds_req_p = ~chip_sel & ~sleep;

  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= 3'd0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assert_flow_read_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd2 && flow_mode && $past(rd_req_p, 2) && oe && !sleep) |-> dout_en);

  assert_pipe_read_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3 && !flow_mode && $past(rd_req_p, 3) && oe && !sleep) |-> dout_en);

  assert_dual_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && !flow_mode && dual_desel && $past(ds_req_p, 3) &&
     $past(rd_req_p, 4) && oe && !sleep) |-> dout_en);

  assert_single_release_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3 && !flow_mode && !dual_desel && $past(ds_req_p, 3)) |-> !dout_en);

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !dout_en);

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_en);

endmodule

// File: tb/sync_sram_core_tb.sv
module sync_sram_core_tb;

  localparam int ADDR_W = 6;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, flow_mode, dual_desel, par_odd, oe, sleep;
  logic          chip_sel, wr_all, wr_byte;
  logic [1:0]    lane_sel;
  logic [5:0]    addr;
  logic [DW-1:0] din, dout;
  logic          dout_en, par_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  sync_sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst(rst), .flow_mode(flow_mode), .dual_desel(dual_desel),
    .par_odd(par_odd), .oe(oe), .sleep(sleep), .chip_sel(chip_sel),
    .wr_all(wr_all), .wr_byte(wr_byte), .lane_sel(lane_sel), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .par_err(par_err)
  );

  localparam logic [DW-1:0] BG = {9'h1F0, 9'h00F};
  localparam logic [DW-1:0] V5 = {9'h123, 9'h045};
  localparam logic [DW-1:0] V6 = {9'h0AB, 9'h1CD};
  localparam logic [DW-1:0] V7 = {9'h1F0, 9'h022};

  // {flow, wr_all, wr_byte, lane_sel, addr, write data, expected readback}
  localparam logic [46:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b0, 2'b00, 6'd5,  9'h123, 9'h045, 9'h123, 9'h045},
    {1'b1, 1'b1, 1'b1, 2'b01, 6'd6,  9'h0AB, 9'h1CD, 9'h0AB, 9'h1CD},
    {1'b0, 1'b0, 1'b1, 2'b01, 6'd7,  9'h111, 9'h022, 9'h1F0, 9'h022},
    {1'b1, 1'b0, 1'b1, 2'b10, 6'd8,  9'h111, 9'h022, 9'h111, 9'h00F},
    {1'b0, 1'b0, 1'b1, 2'b11, 6'd63, 9'h1FF, 9'h000, 9'h1FF, 9'h000},
    {1'b1, 1'b0, 1'b0, 2'b11, 6'd0,  9'h055, 9'h066, 9'h1F0, 9'h00F},
    {1'b0, 1'b0, 1'b1, 2'b00, 6'd9,  9'h0C3, 9'h13C, 9'h1F0, 9'h00F},
    {1'b1, 1'b1, 1'b0, 2'b10, 6'd10, 9'h0F0, 9'h10F, 9'h0F0, 9'h10F}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    chip_sel = 1'b0; wr_all = 1'b0; wr_byte = 1'b0; lane_sel = 2'b00;
  endtask

  task automatic issue(input logic c, input logic g, input logic b,
                       input logic [1:0] s, input logic [5:0] a, input logic [DW-1:0] d);
    chip_sel = c; wr_all = g; wr_byte = b; lane_sel = s; addr = a; din = d;
    step();
  endtask

  task automatic read_once(input logic [5:0] a);
    issue(1'b1, 1'b0, 1'b0, 2'b00, a, '0);
    go_idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flow_mode = 1'b0; dual_desel = 1'b0; par_odd = 1'b0;
    oe = 1'b1; sleep = 1'b0; addr = '0; din = '0;
    go_idle();
    repeat (3) step();
    check("R1 dout_en in reset", 32'(dout_en), 32'd0);
    check("R1 par_err in reset", 32'(par_err), 32'd0);
    rst = 1'b0;
    step();
    check("R1 dout_en after reset", 32'(dout_en), 32'd0);

    // Table: background word, then the entry's write, then readback.
    for (int i = 0; i < 8; i++) begin
      logic [46:0] e;
      e = VEC[i];
      flow_mode = e[46];
      issue(1'b1, 1'b1, 1'b0, 2'b00, e[41:36], BG);
      issue(1'b1, e[45], e[44], e[43:42], e[41:36], e[35:18]);
      read_once(e[41:36]);
      step();
      if (!e[46]) step();
      check($sformatf("R2/R3 R4 R5 entry %0d dout", i), 32'(dout), 32'(e[17:0]));
      check($sformatf("R2/R3 entry %0d dout_en", i), 32'(dout_en), 32'd1);
      step();
    end

    // R11: back-to-back pipelined reads.
    flow_mode = 1'b0; dual_desel = 1'b0;
    issue(1'b1, 1'b0, 1'b0, 2'b00, 6'd5, '0);
    issue(1'b1, 1'b0, 1'b0, 2'b00, 6'd6, '0);
    issue(1'b1, 1'b0, 1'b0, 2'b00, 6'd7, '0);
    check("R11 first", 32'(dout), 32'(V5));
    go_idle();
    step();
    check("R11 second", 32'(dout), 32'(V6));
    step();
    check("R11 third", 32'(dout), 32'(V7));
    check("R11 drive", 32'(dout_en), 32'd1);
    repeat (3) step();

    // R7 single-cycle release, pipelined.
    read_once(6'd5); step(); step();
    check("R7 pipe data cycle", 32'(dout_en), 32'd1);
    step();
    check("R7 pipe released", 32'(dout_en), 32'd0);
    repeat (2) step();

    // R6 dual-cycle release, pipelined.
    dual_desel = 1'b1;
    read_once(6'd5); step(); step();
    check("R6 pipe data cycle", 32'(dout_en), 32'd1);
    step();
    check("R6 pipe hold drive", 32'(dout_en), 32'd1);
    check("R6 pipe hold data", 32'(dout), 32'(V5));
    step();
    check("R6 pipe released", 32'(dout_en), 32'd0);
    repeat (2) step();

    // R7 and R6 in flow-through.
    flow_mode = 1'b1; dual_desel = 1'b0;
    read_once(6'd5); step();
    check("R7 flow data cycle", 32'(dout_en), 32'd1);
    step();
    check("R7 flow released", 32'(dout_en), 32'd0);
    repeat (2) step();
    dual_desel = 1'b1;
    read_once(6'd5); step();
    check("R6 flow data cycle", 32'(dout), 32'(V5));
    step();
    check("R6 flow hold", 32'(dout_en), 32'd1);
    step();
    check("R6 flow released", 32'(dout_en), 32'd0);
    repeat (2) step();

    // R8 parity, pipelined.
    flow_mode = 1'b0; dual_desel = 1'b0; par_odd = 1'b0;
    issue(1'b1, 1'b1, 1'b0, 2'b00, 6'd20, {9'h003, 9'h003});
    issue(1'b1, 1'b1, 1'b0, 2'b00, 6'd21, {9'h003, 9'h007});
    read_once(6'd20); step(); step();
    check("R8 even ok", 32'(par_err), 32'd0);
    repeat (2) step();
    par_odd = 1'b1;
    read_once(6'd20); step();
    check("R8 before data cycle", 32'(par_err), 32'd0);
    step();
    check("R8 odd mismatch", 32'(par_err), 32'd1);
    check("R8 same cycle drive", 32'(dout_en), 32'd1);
    step();
    check("R8 after data cycle", 32'(par_err), 32'd0);
    par_odd = 1'b0;
    read_once(6'd21); step(); step();
    check("R8 even lane0 bad", 32'(par_err), 32'd1);
    repeat (2) step();

    // R9 asynchronous output enable inside a data cycle.
    read_once(6'd5); step(); step();
    oe = 1'b0; #1;
    check("R9 oe low", 32'(dout_en), 32'd0);
    oe = 1'b1; #1;
    check("R9 oe high", 32'(dout_en), 32'd1);
    repeat (2) step();

    // R10 asynchronous sleep and ignored commands.
    read_once(6'd5); step(); step();
    sleep = 1'b1; #1;
    check("R10 sleep forces off", 32'(dout_en), 32'd0);
    sleep = 1'b0; #1;
    check("R10 wake restores", 32'(dout_en), 32'd1);
    repeat (2) step();
    issue(1'b1, 1'b1, 1'b0, 2'b00, 6'd30, V6);
    go_idle(); repeat (2) step();
    sleep = 1'b1;
    issue(1'b1, 1'b1, 1'b0, 2'b00, 6'd30, V7);
    issue(1'b1, 1'b0, 1'b0, 2'b00, 6'd30, '0);
    sleep = 1'b0;
    go_idle();
    step(); step();
    check("R10 ignored read not driven", 32'(dout_en), 32'd0);
    read_once(6'd30); step(); step();
    check("R10 contents kept", 32'(dout), 32'(V6));
    repeat (2) step();

    // R1 reset in the middle of a read.
    read_once(6'd5);
    rst = 1'b1;
    step();
    check("R1 reset clears read", 32'(dout_en), 32'd0);
    step();
    check("R1 reset clears parity flag", 32'(par_err), 32'd0);
    rst = 1'b0;
    step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule